// File: doc/BRIEF.md
# Real-Time Clock Register Bank

This block is the software-visible register file of a real-time clock. Software reaches it through two byte ports that share one bus: a write to the selector port stores an index, and every later read or write of the data port acts on the register that index names. The bank holds the clock's time and calendar bytes, the alarm bytes, two writable control registers, two read-only status registers and general-purpose RAM. The bank size is a parameter of 64 or 128 bytes.

A write to a control register or to a time byte is not a plain store. The control bytes are reshaped on the way in, the status bytes refuse writes, and a write to a time byte raises a one-cycle reload strobe that tells a separate timekeeping core to reload its count. While software holds the clock in set mode, those reloads are held back and one strobe is released when set mode ends. The update-in-progress flag belongs to the timekeeping core, which drives it through an input. Counting time, raising interrupts and keeping the bytes across power loss are all outside this block.

Top module: `rtcb_bank`

## Requirements
- R1: With `io_sel`=0, an `io_wr` stores `wr_data` as the index. With `io_sel`=1, an `io_wr` writes the indexed byte, and an `io_rd` loads that byte into `rd_data` at the same clock edge. A general RAM byte (for example index 0x20) reads back exactly what was written.
- R2: An index at or above `NREGS` is out of range. A data-port read of it returns 0xFF. A data-port write to it changes no byte, including the byte whose low index bits match. Either access sets `range_err` high for the single cycle after the access edge.
- R3: A write to control B (index 0x0B) always stores bit 3 as 0. If the written bit 7 is 1, bit 4 is stored as 0 as well.
- R4: A write to control A (index 0x0A) takes bits 6:0 from `wr_data`. Bit 7 is never written by software and follows `tick_busy`, which is sampled on every clock.
- R5: While control B bit 7 (set mode) is 1, a read of control A returns bit 7 as 0. Bits 6:0 are not affected.
- R6: Writes to status C (0x0C) and status D (0x0D) are ignored. Both always read 0x00.
- R7: The time bytes are 0x00, 0x02, 0x04, 0x06, 0x07, 0x08, 0x09, 0x32 and 0x37. A write to one of them while set mode is 0 raises `reload_pulse` for exactly the cycle after the write edge.
- R8: A time-byte write while set mode is 1 stores the byte, raises no strobe and marks a pending reload. A control B write that takes bit 7 from 1 to 0 while a reload is pending raises one strobe and clears the mark. The same transition with nothing pending raises no strobe.
- R9: A write to the alternate century byte (0x37) also stores the value in the century byte (0x32).
- R10: After reset, control A reads 0x26, control B reads 0x02, every other byte reads 0x00, and `rd_data`, `reload_pulse` and `range_err` are 0.
- R11: The alarm bytes (0x01, 0x03, 0x05) and the RAM bytes store plain values and never raise `reload_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | Write strobe for the port picked by io_sel |
| io_rd | input | 1 | Read strobe; only acts on the data port |
| io_sel | input | 1 | 0 = index port, 1 = data port |
| wr_data | input | 8 | Write data |
| tick_busy | input | 1 | Update-in-progress flag from the timekeeping core |
| rd_data | output | 8 | Data-port read result, registered |
| reload_pulse | output | 1 | One-cycle request to reload the time count |
| range_err | output | 1 | One-cycle flag for an out-of-range data access |

## Verification
Two sources can act on control A in the same cycle: the timekeeping core samples its busy flag into bit 7, and software writes the other bits. The bench holds `tick_busy` at 1 or at 0 while it writes control A with the opposite bit 7, then reads the byte back. Bit 7 must follow `tick_busy` and bits 6:0 must follow the write. The bench then repeats the read in set mode, where bit 7 must read as 0 even though `tick_busy` is high. It also checks that ending set mode releases exactly one held-back strobe, and none on a second exit.

// File: rtl/rtcb_pkg.sv
package rtcb_pkg;

    typedef logic [7:0] byte_t;

    // Register positions that software decodes
    localparam byte_t R_SEC      = 8'h00;
    localparam byte_t R_SEC_ALM  = 8'h01;
    localparam byte_t R_MIN      = 8'h02;
    localparam byte_t R_MIN_ALM  = 8'h03;
    localparam byte_t R_HOUR     = 8'h04;
    localparam byte_t R_HOUR_ALM = 8'h05;
    localparam byte_t R_WDAY     = 8'h06;
    localparam byte_t R_MDAY     = 8'h07;
    localparam byte_t R_MONTH    = 8'h08;
    localparam byte_t R_YEAR     = 8'h09;
    localparam byte_t R_CTL_A    = 8'h0A;
    localparam byte_t R_CTL_B    = 8'h0B;
    localparam byte_t R_STS_C    = 8'h0C;
    localparam byte_t R_STS_D    = 8'h0D;
    localparam byte_t R_CENT     = 8'h32;
    localparam byte_t R_CENT_ALT = 8'h37;

    localparam byte_t CTL_A_RST  = 8'h26;
    localparam byte_t CTL_B_RST  = 8'h02;
    localparam byte_t OOR_VALUE  = 8'hFF;

    // One data-port access, as seen by the storage
    typedef struct packed {
        logic  wr;
        logic  rd;
        logic  oor;
        byte_t idx;
        byte_t data;
    } access_t;

    function automatic logic is_time_reg(input byte_t idx);
        case (idx)
            R_SEC, R_MIN, R_HOUR, R_WDAY, R_MDAY,
            R_MONTH, R_YEAR, R_CENT, R_CENT_ALT: return 1'b1;
            default:                              return 1'b0;
        endcase
    endfunction

    // Control B write filter: bit 3 never stored, set mode drops bit 4
    function automatic byte_t shape_ctl_b(input byte_t d);
        byte_t v;
        v    = d;
        v[3] = 1'b0;
        if (v[7]) v[4] = 1'b0;
        return v;
    endfunction

endpackage

// File: rtl/rtcb_index.sv
module rtcb_index
    import rtcb_pkg::*;
#(
    parameter int NREGS = 64
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    io_wr,
    input  logic    io_rd,
    input  logic    io_sel,
    input  byte_t   wr_data,
    output byte_t   idx_q,
    output access_t acc,
    output logic    err_q
);

    localparam byte_t LIMIT = 8'(NREGS);

    logic oor;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
            err_q <= 1'b0;
        end else begin
            if (io_wr && !io_sel) idx_q <= wr_data;
            err_q <= io_sel && (io_wr || io_rd) && oor;
        end
    end

    assign oor = (idx_q >= LIMIT);

    always_comb begin
        acc.wr   = io_wr && io_sel;
        acc.rd   = io_rd && io_sel;
        acc.oor  = oor;
        acc.idx  = idx_q;
        acc.data = wr_data;
    end

endmodule

// File: rtl/rtcb_store.sv
module rtcb_store
    import rtcb_pkg::*;
#(
    parameter int NREGS = 64
) (
    input  logic    clk,
    input  logic    rst,
    input  access_t acc,
    input  logic    tick_busy,
    output byte_t   rd_data,
    output byte_t   ctl_b_q,
    output logic    time_wr,
    output logic    ctl_b_wr
);

    localparam int AW = $clog2(NREGS);

    byte_t ram [NREGS];
    byte_t ctl_a_q;
    byte_t rd_q;
    byte_t view;
    logic  wr_ok;

    logic [AW-1:0] waddr;
    logic [AW-1:0] cent_addr;

    assign wr_ok     = acc.wr && !acc.oor;
    assign waddr     = acc.idx[AW-1:0];
    assign cent_addr = R_CENT[AW-1:0];
    assign time_wr   = wr_ok && is_time_reg(acc.idx);
    assign ctl_b_wr  = wr_ok && (acc.idx == R_CTL_B);

    // Control registers kept apart from the plain array
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_a_q <= CTL_A_RST;
            ctl_b_q <= CTL_B_RST;
        end else begin
            ctl_a_q[7] <= tick_busy;
            if (wr_ok && acc.idx == R_CTL_A) ctl_a_q[6:0] <= acc.data[6:0];
            if (ctl_b_wr) ctl_b_q <= shape_ctl_b(acc.data);
        end
    end

    // Plain byte array: time, alarm, RAM
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++) ram[i] <= '0;
        end else if (wr_ok) begin
            case (acc.idx)
                R_CTL_A, R_CTL_B, R_STS_C, R_STS_D: ;
                R_CENT_ALT: begin
                    ram[waddr]     <= acc.data;
                    ram[cent_addr] <= acc.data;
                end
                default: ram[waddr] <= acc.data;
            endcase
        end
    end

    always_comb begin
        case (acc.idx)
            R_CTL_A:          view = {ctl_a_q[7] & ~ctl_b_q[7], ctl_a_q[6:0]};
            R_CTL_B:          view = ctl_b_q;
            R_STS_C, R_STS_D: view = 8'h00;
            default:          view = ram[waddr];
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         rd_q <= '0;
        else if (acc.rd) rd_q <= acc.oor ? OOR_VALUE : view;
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/rtcb_reload.sv
module rtcb_reload (
    input  logic clk,
    input  logic rst,
    input  logic time_wr,
    input  logic ctl_b_wr,
    input  logic new_set,
    input  logic set_mode,
    output logic reload_pulse
);

    logic pending_q;
    logic pulse_q;
    logic leave_set;

    assign leave_set = ctl_b_wr && set_mode && !new_set;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending_q <= 1'b0;
            pulse_q   <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            if (time_wr) begin
                if (set_mode) pending_q <= 1'b1;
                else          pulse_q   <= 1'b1;
            end
            if (leave_set && pending_q) begin
                pulse_q   <= 1'b1;
                pending_q <= 1'b0;
            end
        end
    end

    assign reload_pulse = pulse_q;

endmodule

// File: rtl/rtcb_bank.sv
module rtcb_bank
    import rtcb_pkg::*;
#(
    parameter int NREGS = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       io_wr,
    input  logic       io_rd,
    input  logic       io_sel,
    input  logic [7:0] wr_data,
    input  logic       tick_busy,
    output logic [7:0] rd_data,
    output logic       reload_pulse,
    output logic       range_err
);

    access_t acc;
    byte_t   idx_q;
    byte_t   ctl_b_q;
    logic    time_wr;
    logic    ctl_b_wr;

    generate
        if (NREGS != 64 && NREGS != 128) begin : g_bad_size
            initial $error("rtcb_bank: NREGS must be 64 or 128");
        end
    endgenerate

    rtcb_index #(.NREGS(NREGS)) u_index (
        .clk     (clk),
        .rst     (rst),
        .io_wr   (io_wr),
        .io_rd   (io_rd),
        .io_sel  (io_sel),
        .wr_data (wr_data),
        .idx_q   (idx_q),
        .acc     (acc),
        .err_q   (range_err)
    );

    rtcb_store #(.NREGS(NREGS)) u_store (
        .clk       (clk),
        .rst       (rst),
        .acc       (acc),
        .tick_busy (tick_busy),
        .rd_data   (rd_data),
        .ctl_b_q   (ctl_b_q),
        .time_wr   (time_wr),
        .ctl_b_wr  (ctl_b_wr)
    );

    rtcb_reload u_reload (
        .clk          (clk),
        .rst          (rst),
        .time_wr      (time_wr),
        .ctl_b_wr     (ctl_b_wr),
        .new_set      (wr_data[7]),
        .set_mode     (ctl_b_q[7]),
        .reload_pulse (reload_pulse)
    );

endmodule

// File: rtl/rtcb_bank_chk.sv
module rtcb_bank_chk #(
    parameter int NREGS = 64
) (
    input logic       clk,
    input logic       rst,
    input logic       io_wr,
    input logic       io_rd,
    input logic       io_sel,
    input logic [7:0] idx_q,
    input logic       set_mode,
    input logic [7:0] rd_data,
    input logic       reload_pulse,
    input logic       range_err
);

    logic oor;
    assign oor = (idx_q >= 8'(NREGS));

    p_err_source_r2: assert property (@(posedge clk) disable iff (rst)
        range_err |-> $past(io_sel && (io_wr || io_rd) && oor));

    p_oor_read_ff_r2: assert property (@(posedge clk) disable iff (rst)
        (io_rd && io_sel && oor) |=> (rd_data == 8'hFF));

    p_ctl_b_bit3_r3: assert property (@(posedge clk) disable iff (rst)
        (io_rd && io_sel && idx_q == 8'h0B) |=> (rd_data[3] == 1'b0));

    p_uip_masked_r5: assert property (@(posedge clk) disable iff (rst)
        (io_rd && io_sel && idx_q == 8'h0A && set_mode) |=> (rd_data[7] == 1'b0));

    p_status_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (io_rd && io_sel && (idx_q == 8'h0C || idx_q == 8'h0D)) |=> (rd_data == 8'h00));

    p_reload_source_r7: assert property (@(posedge clk) disable iff (rst)
        reload_pulse |-> $past(io_wr && io_sel));

    p_set_mode_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (io_wr && io_sel && set_mode && !oor && idx_q != 8'h0B) |=> !reload_pulse);

endmodule

bind rtcb_bank rtcb_bank_chk #(.NREGS(NREGS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .io_wr        (io_wr),
    .io_rd        (io_rd),
    .io_sel       (io_sel),
    .idx_q        (idx_q),
    .set_mode     (ctl_b_q[7]),
    .rd_data      (rd_data),
    .reload_pulse (reload_pulse),
    .range_err    (range_err)
);

// File: tb/test_rtcb_bank.sv
module test_rtcb_bank;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       io_wr = 1'b0;
    logic       io_rd = 1'b0;
    logic       io_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       tick_busy = 1'b0;
    logic [7:0] rd_data;
    logic       reload_pulse;
    logic       range_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [7:0] model [256];
    logic [7:0] got;

    always #2 clk = ~clk;

    rtcb_bank #(.NREGS(64)) i_rtcb_bank (
        .clk (clk), .rst (rst), .io_wr (io_wr), .io_rd (io_rd),
        .io_sel (io_sel), .wr_data (wr_data), .tick_busy (tick_busy),
        .rd_data (rd_data), .reload_pulse (reload_pulse), .range_err (range_err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic sel_reg(input logic [7:0] idx);
        @(negedge clk);
        io_wr = 1'b1; io_sel = 1'b0; wr_data = idx;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    // After return, the cycle following the write edge is visible
    task automatic put(input logic [7:0] idx, input logic [7:0] v);
        sel_reg(idx);
        io_wr = 1'b1; io_sel = 1'b1; wr_data = v;
        @(negedge clk);
        io_wr = 1'b0; io_sel = 1'b0;
    endtask

    task automatic get(input logic [7:0] idx, output logic [7:0] v);
        sel_reg(idx);
        io_rd = 1'b1; io_sel = 1'b1;
        @(negedge clk);
        io_rd = 1'b0; io_sel = 1'b0;
        v = rd_data;
    endtask

    function automatic logic [7:0] time_reg_at(input int k);
        case (k)
            0: return 8'h00; 1: return 8'h02; 2: return 8'h04;
            3: return 8'h06; 4: return 8'h07; 5: return 8'h08;
            6: return 8'h09; 7: return 8'h32; default: return 8'h37;
        endcase
    endfunction

    initial begin : watchdog
        #400000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin : main
        int seed;
        seed = $urandom(32'h5EED);
        for (int i = 0; i < 256; i++) model[i] = 8'h00;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10 reset state
        chk(rd_data == 8'h00, "R10 rd_data", rd_data, 0);
        chk(reload_pulse == 1'b0 && range_err == 1'b0, "R10 strobes", {reload_pulse, range_err}, 0);
        get(8'h0A, got); chk(got == 8'h26, "R10 ctl A", got, 8'h26);
        get(8'h0B, got); chk(got == 8'h02, "R10 ctl B", got, 8'h02);
        get(8'h04, got); chk(got == 8'h00, "R10 hour", got, 0);

        // R1 plain RAM byte
        put(8'h20, 8'hC3);
        chk(!reload_pulse, "R11 ram no reload", reload_pulse, 0);
        get(8'h20, got); chk(got == 8'hC3, "R1 ram readback", got, 8'hC3);
        model[8'h20] = 8'hC3;

        // R11 alarm byte
        put(8'h01, 8'h30);
        chk(!reload_pulse, "R11 alarm no reload", reload_pulse, 0);
        get(8'h01, got); chk(got == 8'h30, "R11 alarm readback", got, 8'h30);

        // R7 time write, normal mode
        put(8'h00, 8'h45);
        chk(reload_pulse, "R7 pulse after sec write", reload_pulse, 1);
        @(negedge clk);
        chk(!reload_pulse, "R7 pulse one cycle", reload_pulse, 0);

        // R2 out of range (0x40 aliases index 0x00 in low bits)
        put(8'h40, 8'h5A);
        chk(range_err, "R2 err on write", range_err, 1);
        @(negedge clk);
        chk(!range_err, "R2 err one cycle", range_err, 0);
        get(8'h40, got);
        chk(got == 8'hFF, "R2 read ff", got, 8'hFF);
        chk(range_err, "R2 err on read", range_err, 1);
        put(8'hFF, 8'h11);
        get(8'h00, got); chk(got == 8'h45, "R2 alias untouched", got, 8'h45);
        get(8'h3F, got); chk(got == 8'h00 && !range_err, "R2 last in range", got, 0);

        // R3 control B shaping
        put(8'h0B, 8'h9A);
        get(8'h0B, got); chk(got == 8'h82, "R3 set mode drops bits 3,4", got, 8'h82);
        put(8'h0B, 8'h1E);
        chk(!reload_pulse, "R8 exit without pending", reload_pulse, 0);
        get(8'h0B, got); chk(got == 8'h16, "R3 bit3 cleared", got, 8'h16);
        put(8'h0B, 8'h02);

        // R4 control A: bit 7 from tick_busy, same-cycle write
        tick_busy = 1'b1;
        put(8'h0A, 8'h00);
        get(8'h0A, got); chk(got == 8'h80, "R4 busy=1 write 00", got, 8'h80);
        tick_busy = 1'b0;
        put(8'h0A, 8'hA5);
        get(8'h0A, got); chk(got == 8'h25, "R4 busy=0 write a5", got, 8'h25);

        // R5 masking in set mode
        tick_busy = 1'b1;
        put(8'h0B, 8'h82);
        get(8'h0A, got); chk(got == 8'h25, "R5 bit7 masked", got, 8'h25);

        // R8 deferred reload (still in set mode)
        put(8'h04, 8'h11);
        chk(!reload_pulse, "R8 no pulse in set mode", reload_pulse, 0);
        put(8'h08, 8'h07);
        chk(!reload_pulse, "R8 no pulse second write", reload_pulse, 0);
        put(8'h0B, 8'h02);
        chk(reload_pulse, "R8 pulse on exit", reload_pulse, 1);
        get(8'h0A, got); chk(got == 8'hA5, "R5 bit7 visible after exit", got, 8'hA5);
        tick_busy = 1'b0;
        get(8'h04, got); chk(got == 8'h11, "R8 held byte stored", got, 8'h11);
        put(8'h0B, 8'h82);
        put(8'h0B, 8'h02);
        chk(!reload_pulse, "R8 pending cleared", reload_pulse, 0);

        // R6 status bytes
        put(8'h0C, 8'h55);
        get(8'h0C, got); chk(got == 8'h00, "R6 status C", got, 0);
        put(8'h0D, 8'hAA);
        get(8'h0D, got); chk(got == 8'h00, "R6 status D", got, 0);

        // R9 alternate century copy
        put(8'h37, 8'h20);
        chk(reload_pulse, "R7 pulse on alt century", reload_pulse, 1);
        get(8'h32, got); chk(got == 8'h20, "R9 century copy", got, 8'h20);
        get(8'h37, got); chk(got == 8'h20, "R9 alt century", got, 8'h20);

        // Random RAM traffic and time writes
        for (int n = 0; n < 60; n++) begin
            logic [7:0] a;
            logic [7:0] v;
            a = 8'h10 + 8'($urandom_range(0, 31));
            v = 8'($urandom);
            put(a, v);
            model[a] = v;
            chk(!reload_pulse, "R11 random ram no reload", reload_pulse, 0);
            a = 8'h10 + 8'($urandom_range(0, 31));
            get(a, got);
            chk(got == model[a], "R1 random readback", got, model[a]);
            a = time_reg_at($urandom_range(0, 8));
            put(a, v);
            chk(reload_pulse, "R7 random time write", reload_pulse, 1);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule